// File: doc/BRIEF.md
# Serial LED Shift-Out Engine

This block drives an external serial-in/parallel-out shift register that fans out 17 LED or general-purpose outputs. A 17-bit word is sent most-significant bit first on a serial data line. A serial clock is derived from the system clock through a selectable divider. A one-cycle strobe at the end moves the shifted word to the external register's outputs. A programmable delay sets how many system cycles the data line is held before each serial clock rising edge.

Words come from one of two sources. In software mode a write strobe hands the engine a word, and the write is honoured only while the engine is idle. In PWM mode the engine watches the 17 outputs of a PWM bank and starts a new transfer each time that vector differs from the last word sent. The last word sent resets to zero, so a vector that stays all-zero never starts a transfer. Software normally sends an all-zero word first to clear the external register, and only then selects PWM mode.

The control path is a three-state machine:
- `ST_IDLE` goes to `ST_SHIFT` when a transfer starts.
- `ST_SHIFT` goes to `ST_LATCH` at the end of the bit period of the 17th bit.
- `ST_LATCH` always returns to `ST_IDLE` after one cycle.

The busy output is high in every state except `ST_IDLE`.

Top module: `sled_shift_out`

## Requirements
- R1: After reset, `busy`, `sclk`, `sdata` and `latch` are all 0.
- R2: In software mode, a `wr_en` pulse while idle starts a transfer. `busy` reads 1 from the next cycle, and stays 1 for exactly 17*N+1 cycles, where N is the divide ratio.
- R3: A `wr_en` pulse while `busy` is 1 is ignored. It neither changes the word being sent nor queues a second transfer.
- R4: Each transfer gives exactly 17 `sclk` rising edges. The value of `sdata` at the k-th rising edge is bit 16-(k-1) of the word, so the MSB goes first. `sdata` does not change while `sclk` is high.
- R5: `div_sel` values 0, 1, 2 and 3 give N = 4, 8, 16 and 32. Every `sclk` high phase lasts N/2 cycles.
- R6: The first `sclk` rising edge comes D+1 cycles after `sdata` takes the first bit. D is the programmed delay `dly_cfg`; a value above N/2-1 is treated as N/2-1.
- R7: With `mode_alt` = 0, `latch` is high for exactly one cycle in each transfer. That cycle comes after the 17th `sclk` falling edge, with `sclk` low, in the last cycle that `busy` is 1.
- R8: With `mode_alt` = 1, no `latch` pulse is issued. Transfer timing is unchanged.
- R9: PWM mode can be entered or left only while the engine is idle. While PWM mode is active, `wr_en` is ignored.
- R10: In PWM mode the idle engine starts a transfer of `pwm_vec` whenever it differs from the last word sent; that word is zero after reset. An unchanged vector starts nothing, and returning to all-zero sends zeros.
- R11: `div_sel`, `dly_cfg` and `mode_alt` are captured when a transfer starts. Changing them during a transfer does not affect that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe for a new word |
| wr_data | input | 17 | Software word to send |
| div_sel | input | 2 | Serial clock divider select (N = 4 << div_sel) |
| dly_cfg | input | 4 | Data-to-clock delay; actual delay is value+1 cycles |
| mode_pwm | input | 1 | Selects the PWM vector as the data source |
| mode_alt | input | 1 | Alternate protocol: no latch strobe |
| pwm_vec | input | 17 | Outputs of the PWM bank for the serial pins |
| busy | output | 1 | Transfer in progress |
| sdata | output | 1 | Serial data, MSB first |
| sclk | output | 1 | Serial clock |
| latch | output | 1 | One-cycle transfer strobe |

## Verification
A wrong phase counter or a wrongly captured divider changes the `sclk` high width or the count of cycles `busy` stays high. The bench measures both on the transfer that goes wrong. A slipped bit counter or shift register shows up as a wrong captured word or a count of rising edges other than 17, seen when that transfer ends. A stale last-word register in PWM mode shows up within a few cycles of a vector change: either a transfer starts when nothing should move, or no transfer starts when one should.

// File: rtl/sled_pkg.sv
package sled_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2
    } sled_state_e;
endpackage

// File: rtl/sled_bit_timer.sv
// Bit-period timer: phase counter per bit, serial clock with a
// programmable data-to-clock delay, divide ratio captured at load.
module sled_bit_timer #(
    parameter int DIV_W = 2,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [DLY_W-1:0] dly_cfg,
    output logic             bit_end,
    output logic             sclk
);
    // largest ratio is 4 << (2^DIV_W - 1); the phase counter needs one bit fewer
    localparam int PH_W = 1 + (1 << DIV_W);

    logic [PH_W-1:0] half_in, dly_ext, dly_lim;
    logic [PH_W-1:0] half_q, dly_q, last_q, phase_q;

    always_comb begin
        half_in = PH_W'(2) << div_sel;
        dly_ext = PH_W'(dly_cfg);
        dly_lim = (dly_ext > half_in - PH_W'(1)) ? half_in - PH_W'(1) : dly_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= '0;
            dly_q   <= '0;
            last_q  <= '0;
            phase_q <= '0;
            sclk    <= 1'b0;
        end else if (load) begin
            half_q  <= half_in;
            dly_q   <= dly_lim;
            last_q  <= (half_in << 1) - PH_W'(1);
            phase_q <= '0;
            sclk    <= 1'b0;
        end else if (run) begin
            phase_q <= (phase_q == last_q) ? '0 : phase_q + PH_W'(1);
            if (phase_q == dly_q)
                sclk <= 1'b1;
            else if (phase_q == dly_q + half_q)
                sclk <= 1'b0;
        end else begin
            sclk <= 1'b0;
        end
    end

    assign bit_end = run && (phase_q == last_q);
endmodule

// File: rtl/sled_shifter.sv
// MSB-first parallel-to-serial register with bit counter.
module sled_shifter #(
    parameter int WORD_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              advance,
    output logic              sdata,
    output logic              last_bit
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] sreg_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
            sdata  <= 1'b0;
        end else if (load) begin
            sreg_q <= word;
            cnt_q  <= '0;
            sdata  <= word[WORD_W-1];
        end else if (advance && !last_bit) begin
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
            cnt_q  <= cnt_q + CNT_W'(1);
            sdata  <= sreg_q[WORD_W-2];
        end
    end

    assign last_bit = (cnt_q == CNT_W'(WORD_W - 1));
endmodule

// File: rtl/sled_src_sel.sv
// Chooses the word source and decides when a transfer starts.
module sled_src_sel #(
    parameter int WORD_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              mode_pwm,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] pwm_vec,
    output logic              start,
    output logic [WORD_W-1:0] start_word,
    output logic              pwm_act
);
    logic [WORD_W-1:0] last_q;

    always_comb begin
        start_word = pwm_act ? pwm_vec : wr_data;
        start      = idle && (pwm_act ? (pwm_vec != last_q) : wr_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_act <= 1'b0;
            last_q  <= '0;
        end else begin
            if (idle)
                pwm_act <= mode_pwm;
            if (start)
                last_q <= start_word;
        end
    end
endmodule

// File: rtl/sled_shift_out.sv
module sled_shift_out #(
    parameter int WORD_W = 17,
    parameter int DIV_W  = 2,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [DLY_W-1:0]  dly_cfg,
    input  logic              mode_pwm,
    input  logic              mode_alt,
    input  logic [WORD_W-1:0] pwm_vec,
    output logic              busy,
    output logic              sdata,
    output logic              sclk,
    output logic              latch
);
    import sled_pkg::*;

    sled_state_e       state_q, state_d;
    logic              start, pwm_act, bit_end, last_bit, alt_q;
    logic [WORD_W-1:0] start_word;
    logic              idle, run;

    assign idle = (state_q == ST_IDLE);
    assign run  = (state_q == ST_SHIFT);
    assign busy = !idle;

    sled_src_sel #(.WORD_W(WORD_W)) u_src (
        .clk(clk), .rst_n(rst_n), .idle(idle), .mode_pwm(mode_pwm),
        .wr_en(wr_en), .wr_data(wr_data), .pwm_vec(pwm_vec),
        .start(start), .start_word(start_word), .pwm_act(pwm_act)
    );

    sled_bit_timer #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(start), .run(run),
        .div_sel(div_sel), .dly_cfg(dly_cfg),
        .bit_end(bit_end), .sclk(sclk)
    );

    sled_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(start), .word(start_word),
        .advance(bit_end), .sdata(sdata), .last_bit(last_bit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SHIFT;
            ST_SHIFT: if (bit_end && last_bit) state_d = ST_LATCH;
            ST_LATCH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alt_q <= 1'b0;
            latch <= 1'b0;
        end else begin
            if (start) alt_q <= mode_alt;
            latch <= run && bit_end && last_bit && !alt_q;
        end
    end
endmodule

// File: rtl/sled_shift_out_chk.sv
module sled_shift_out_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic sclk,
    input logic sdata,
    input logic latch,
    input logic pwm_act
);
    assert_sclk_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> busy);

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));

    assert_latch_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> !latch);

    assert_latch_place_R7: assert property (@(posedge clk) disable iff (!rst_n)
        latch |-> (busy && !sclk));

    assert_latch_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> !busy);

    assert_mode_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwm_act) |-> !$past(busy));
endmodule

bind sled_shift_out sled_shift_out_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk),
    .sdata(sdata), .latch(latch), .pwm_act(pwm_act)
);

// File: tb/sled_shift_out_test.sv
module sled_shift_out_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [16:0] wr_data = '0;
    logic [1:0]  div_sel = '0;
    logic [3:0]  dly_cfg = '0;
    logic        mode_pwm = 1'b0;
    logic        mode_alt = 1'b0;
    logic [16:0] pwm_vec = '0;
    logic        busy, sdata, sclk, latch;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sled_shift_out uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .div_sel(div_sel), .dly_cfg(dly_cfg), .mode_pwm(mode_pwm),
        .mode_alt(mode_alt), .pwm_vec(pwm_vec), .busy(busy),
        .sdata(sdata), .sclk(sclk), .latch(latch)
    );

    // negedge monitor of one transfer
    int          t, busy_len, first_dly, nrise, cur_w, wmin, wmax, nlatch, latch_at;
    logic [16:0] cap;
    logic        pb = 1'b0, ps = 1'b0;
    bit          got_first;

    always @(negedge clk) begin
        if (busy === 1'b1 && !pb) begin
            t = 0; busy_len = 0; got_first = 0; nrise = 0; cur_w = 0;
            wmin = 9999; wmax = 0; nlatch = 0; latch_at = -1; cap = '0;
        end
        if (busy === 1'b1) begin
            busy_len++;
            if (sclk && !ps) begin
                nrise++;
                cap = {cap[15:0], sdata};
                if (!got_first) begin first_dly = t; got_first = 1; end
            end
            if (sclk) cur_w++;
            else if (ps) begin
                if (cur_w < wmin) wmin = cur_w;
                if (cur_w > wmax) wmax = cur_w;
                cur_w = 0;
            end
            if (latch) begin nlatch++; latch_at = nrise; end
            t++;
        end
        pb = (busy === 1'b1);
        ps = (sclk === 1'b1);
    end

    function automatic int ratio(input int d);
        return 4 << d;
    endfunction

    function automatic int eff_dly(input int d, input int dv);
        int h;
        h = ratio(dv) / 2;
        return (d > h - 1) ? h - 1 : d;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wait_done();
        int g;
        g = 0;
        while (busy && g < 3000) begin
            step(1);
            g++;
        end
    endtask

    task automatic wait_start(input int lim);
        int g;
        g = 0;
        while (!busy && g < lim) begin
            step(1);
            g++;
        end
    endtask

    task automatic sw_write(input logic [16:0] w);
        wr_data = w;
        wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
        chk("R2 busy after write", busy, 1);
    endtask

    task automatic check_xfer(input logic [16:0] w, input int dv, input int d, input bit alt);
        int n;
        n = ratio(dv);
        chk("R4 word MSB first", cap, w);
        chk("R4 rising edge count", nrise, 17);
        chk("R2 busy length", busy_len, 17 * n + 1);
        chk("R5 sclk high min", wmin, n / 2);
        chk("R5 sclk high max", wmax, n / 2);
        chk("R6 first clock delay", first_dly, eff_dly(d, dv) + 1);
        if (alt) chk("R8 no latch in alt mode", nlatch, 0);
        else begin
            chk("R7 latch count", nlatch, 1);
            chk("R7 latch after last bit", latch_at, 17);
        end
    endtask

    task automatic run_sw(input logic [16:0] w, input int dv, input int d, input bit alt);
        div_sel = 2'(dv);
        dly_cfg = 4'(d);
        mode_alt = alt;
        sw_write(w);
        wait_done();
        check_xfer(w, dv, d, alt);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 busy reset", busy, 0);
        chk("R1 sclk reset", sclk, 0);
        chk("R1 sdata reset", sdata, 0);
        chk("R1 latch reset", latch, 0);

        // directed corners
        run_sw(17'h10001, 0, 0, 0);
        run_sw(17'h1FFFF, 3, 15, 0);
        run_sw(17'h0AAAA, 1, 3, 1);
        run_sw(17'h15555, 0, 9, 0);   // delay clamped to N/2-1 (R6)
        run_sw(17'h00F0F, 2, 7, 0);

        // R3: write while busy ignored
        div_sel = 2'd1; dly_cfg = 4'd2; mode_alt = 1'b0;
        sw_write(17'h12345);
        step(30);
        wr_data = 17'h0BEEF; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
        wait_done();
        chk("R3 word unchanged by busy write", cap, 17'h12345);
        step(20);
        chk("R3 no queued transfer", busy, 0);

        // R11: config changes during a transfer
        div_sel = 2'd0; dly_cfg = 4'd0; mode_alt = 1'b0;
        sw_write(17'h1C3A5);
        step(10);
        div_sel = 2'd3; dly_cfg = 4'd9; mode_alt = 1'b1;
        wait_done();
        chk("R11 busy length kept", busy_len, 17 * 4 + 1);
        chk("R11 sclk width kept", wmax, 2);
        chk("R11 latch kept", nlatch, 1);
        chk("R11 word", cap, 17'h1C3A5);

        // constrained random
        for (int i = 0; i < 20; i++) begin
            logic [16:0] w;
            int dv, d;
            bit alt;
            w = 17'($urandom);
            dv = int'($urandom % 3);
            d = int'($urandom % 16);
            alt = ($urandom % 4) == 0;
            run_sw(w, dv, d, alt);
        end

        // PWM mode: clear external register first, then enable
        run_sw(17'h00000, 0, 1, 0);
        pwm_vec = '0;
        mode_pwm = 1'b1;
        step(20);
        chk("R10 zero vector starts nothing", busy, 0);
        wr_data = 17'h1FFFF; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
        step(10);
        chk("R9 write ignored in PWM mode", busy, 0);
        pwm_vec = 17'h0C0DE;
        wait_start(10);
        chk("R10 vector change starts shift", busy, 1);
        wait_done();
        chk("R10 PWM word sent", cap, 17'h0C0DE);
        step(20);
        chk("R10 unchanged vector idle", busy, 0);
        pwm_vec = 17'h00000;
        wait_start(10);
        chk("R10 return to zero starts shift", busy, 1);
        wait_done();
        chk("R10 zero word sent", cap, 0);
        mode_pwm = 1'b0;
        step(3);
        run_sw(17'h1A5A5, 1, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule